// File: doc/BRIEF.md
# Cascadable Masked Match Table

This block holds a small table of entries, 16 words of 64 bits by default, each with its own occupied bit. A search key is compared against every occupied entry at once under one of several stored don't-care masks. The lowest-numbered entry that agrees becomes the active index. Three active-low flags are produced: found, several-found and table-full. Each flag is combined with the flag of the table above it, so that several tables can be chained in a priority order.

The same command port is used to maintain the table. It supports write and read at an explicit index with the occupied bit, a write into the lowest empty slot, removal of an entry, and loading of a mask. A step command discards the current best hit so that the next hit in priority order becomes the active index. After every command, `act_idx` shows the index the command touched, so that a side memory holding associated data can be addressed at that index.

Top module: `cam_cascade_top`

## Requirements
- R1: Commands are given on `op`: 0 idle, 1 write at index, 2 read at index, 3 write into lowest empty slot, 4 search, 5 step to next hit, 6 remove, 7 load mask. A write at index (1) stores `wdata` in entry `addr` and sets its occupied bit to `wvalid`. A read (2) returns the stored word on `rdata` and the occupied bit on `rvalid` after the next edge. Both set `act_idx` to `addr`.
- R2: A search uses the mask selected by `mask_sel`, which is loaded by command 7 from `wdata`. A mask bit of 1 makes that key bit compare equal. Empty entries never match.
- R3: After a search, `act_idx` is the lowest index that matches, or all ones if no entry matches.
- R4: `match_n` is low when the last search found a local hit, or when `up_match_n` is low.
- R5: When `up_match_n` is high, `multi_n` is low on two or more local hits from the last search. When `up_match_n` is low, `multi_n` is low on one or more local hits.
- R6: `full_n` is low only when every entry is occupied and `up_full_n` is low. It is high whenever `up_full_n` is high.
- R7: Command 3 writes `wdata` into the lowest empty entry, marks it occupied and puts its index on `act_idx`. When the table is full it writes nothing and shows all ones. Remove (6) clears the occupied bit of `addr` and shows `addr`.
- R8: Step (5) discards the current best hit and shows the next hit, or all ones when no hits remain. The flags are left as they are.
- R9: A search with `sel` low clears all previous hits: no local hit is kept, `act_idx` shows all ones, and the local contributions to the flags are cleared.
- R10: The local contributions to the flags change only on the edge that takes a search and hold through every other command.
- R11: After reset all entries are empty, all masks are zero, `act_idx` is all ones, `rdata`/`rvalid` are zero, and the flags show no local hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stands in for the cycle strobe's rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 3 | Command code (see R1) |
| sel | input | 1 | Device selected for this command |
| addr | input | IDX_W | Entry index for write, read and remove |
| wdata | input | WIDTH | Write data, search key or mask value |
| wvalid | input | 1 | Occupied bit for an indexed write |
| mask_sel | input | MSEL_W | Mask slot used by a search or a mask load |
| up_match_n | input | 1 | Found flag from the higher-priority table |
| up_full_n | input | 1 | Full flag from the higher-priority table |
| act_idx | output | IDX_W | Index touched by the last command |
| rdata | output | WIDTH | Word returned by the last read |
| rvalid | output | 1 | Occupied bit returned by the last read |
| match_n | output | 1 | Chained found flag, active low |
| multi_n | output | 1 | Chained several-found flag, active low |
| full_n | output | 1 | Chained full flag, active low |

## Verification
The hardest state to reach is a full table. The full flag depends on the upstream full input, and a write into a full table must be shown to have no effect. The stimulus first builds a scattered pattern of occupied and empty entries. It then issues lowest-empty writes until no slot remains, with the bench predicting each landing index from its own occupancy model. Only then is the upstream full input toggled, and one more slot write is attempted and read back. Stepping through hits and chained several-found cases are reached by writing duplicate words at separate indices.

// File: rtl/cam_pkg.sv
package cam_pkg;
    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_WRITE = 3'd1,
        OP_READ  = 3'd2,
        OP_WFREE = 3'd3,
        OP_SRCH  = 3'd4,
        OP_STEP  = 3'd5,
        OP_DEL   = 3'd6,
        OP_MASKW = 3'd7
    } cam_op_e;
endpackage

// File: rtl/cam_prio_enc.sv
// Lowest-index-wins encoder; returns all ones when no request is set.
module cam_prio_enc #(
    parameter int N    = 16,
    parameter int IW   = 4
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '1;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/cam_match_array.sv
// One comparator per entry; masked bits are forced equal, empty entries never hit.
module cam_match_array #(
    parameter int N = 16,
    parameter int W = 64
) (
    input  logic [N-1:0][W-1:0] ent,
    input  logic [N-1:0]        occ,
    input  logic [W-1:0]        key,
    input  logic [W-1:0]        dc_mask,
    output logic [N-1:0]        hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = occ[g] && (((ent[g] ^ key) & ~dc_mask) == '0);
    end
endmodule

// File: rtl/cam_flag_logic.sv
// Combines registered local results with the upstream chain inputs.
module cam_flag_logic (
    input  logic loc_any,
    input  logic loc_multi,
    input  logic all_occ,
    input  logic up_match_n,
    input  logic up_full_n,
    output logic match_n,
    output logic multi_n,
    output logic full_n
);
    always_comb begin
        match_n = ~(loc_any | ~up_match_n);
        multi_n = up_match_n ? ~loc_multi : ~loc_any;
        full_n  = ~(all_occ & ~up_full_n);
    end
endmodule

// File: rtl/cam_cascade_top.sv
module cam_cascade_top #(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 64,
    parameter int MASKS   = 4,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int MSEL_W = (MASKS > 1) ? $clog2(MASKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op,
    input  logic              sel,
    input  logic [IDX_W-1:0]  addr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic              wvalid,
    input  logic [MSEL_W-1:0] mask_sel,
    input  logic              up_match_n,
    input  logic              up_full_n,
    output logic [IDX_W-1:0]  act_idx,
    output logic [WIDTH-1:0]  rdata,
    output logic              rvalid,
    output logic              match_n,
    output logic              multi_n,
    output logic              full_n
);
    import cam_pkg::*;

    typedef struct packed {
        logic [ENTRIES-1:0][WIDTH-1:0] ent;
        logic [ENTRIES-1:0]            occ;
        logic [MASKS-1:0][WIDTH-1:0]   msk;
        logic [ENTRIES-1:0]            hits;
        logic                          any;
        logic                          multi;
        logic [IDX_W-1:0]              act;
        logic [WIDTH-1:0]              rdata;
        logic                          rvld;
    } cam_state_t;

    cam_state_t st_d, st_q;
    cam_op_e    op_e;

    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] rest_hits;
    logic [IDX_W-1:0]   hit_idx, free_idx, next_idx;
    logic [WIDTH-1:0]   cur_mask;

    assign op_e      = cam_op_e'(op);
    assign cur_mask  = st_q.msk[mask_sel];
    assign rest_hits = st_q.hits & (st_q.hits - ENTRIES'(1));

    cam_match_array #(.N(ENTRIES), .W(WIDTH)) u_match (
        .ent(st_q.ent), .occ(st_q.occ), .key(wdata), .dc_mask(cur_mask), .hit(hit_vec)
    );

    cam_prio_enc #(.N(ENTRIES), .IW(IDX_W)) u_hit_enc  (.req(hit_vec),    .idx(hit_idx));
    cam_prio_enc #(.N(ENTRIES), .IW(IDX_W)) u_free_enc (.req(~st_q.occ),  .idx(free_idx));
    cam_prio_enc #(.N(ENTRIES), .IW(IDX_W)) u_next_enc (.req(rest_hits),  .idx(next_idx));

    always_comb begin
        st_d = st_q;
        unique case (op_e)
            OP_WRITE: begin
                st_d.ent[addr] = wdata;
                st_d.occ[addr] = wvalid;
                st_d.act       = addr;
            end
            OP_READ: begin
                st_d.rdata = st_q.ent[addr];
                st_d.rvld  = st_q.occ[addr];
                st_d.act   = addr;
            end
            OP_WFREE: begin
                if (!(&st_q.occ)) begin
                    st_d.ent[free_idx] = wdata;
                    st_d.occ[free_idx] = 1'b1;
                end
                st_d.act = (&st_q.occ) ? '1 : free_idx;
            end
            OP_SRCH: begin
                if (sel) begin
                    st_d.hits  = hit_vec;
                    st_d.any   = |hit_vec;
                    st_d.multi = (hit_vec & (hit_vec - ENTRIES'(1))) != '0;
                    st_d.act   = hit_idx;
                end else begin
                    st_d.hits  = '0;
                    st_d.any   = 1'b0;
                    st_d.multi = 1'b0;
                    st_d.act   = '1;
                end
            end
            OP_STEP: begin
                st_d.hits = rest_hits;
                st_d.act  = next_idx;
            end
            OP_DEL: begin
                st_d.occ[addr] = 1'b0;
                st_d.act       = addr;
            end
            OP_MASKW: begin
                st_d.msk[mask_sel] = wdata;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.act <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    cam_flag_logic u_flags (
        .loc_any(st_q.any), .loc_multi(st_q.multi), .all_occ(&st_q.occ),
        .up_match_n(up_match_n), .up_full_n(up_full_n),
        .match_n(match_n), .multi_n(multi_n), .full_n(full_n)
    );

    assign act_idx = st_q.act;
    assign rdata   = st_q.rdata;
    assign rvalid  = st_q.rvld;
endmodule

// File: rtl/cam_cascade_chk.sv
module cam_cascade_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] op,
    input logic       sel,
    input logic       up_match_n,
    input logic       up_full_n,
    input logic       match_n,
    input logic       multi_n,
    input logic       full_n
);
    assert_up_match_forces_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !up_match_n |-> !match_n);

    assert_multi_implies_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !multi_n |-> !match_n);

    assert_up_full_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        up_full_n |-> full_n);

    assert_deselect_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd4 && !sel) |=> (multi_n && (match_n == up_match_n)));

    assert_match_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op != 3'd4) ##1 $stable(up_match_n) |-> $stable(match_n));

    assert_multi_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op != 3'd4) ##1 $stable(up_match_n) |-> $stable(multi_n));
endmodule

bind cam_cascade_top cam_cascade_chk u_chk (
    .clk(clk), .rst_n(rst_n), .op(op), .sel(sel),
    .up_match_n(up_match_n), .up_full_n(up_full_n),
    .match_n(match_n), .multi_n(multi_n), .full_n(full_n)
);

// File: tb/tb_cam_cascade_top.sv
module tb_cam_cascade_top;
    localparam logic [63:0] A  = 64'h1111_2222_3333_4444;
    localparam logic [63:0] B  = 64'h5555_6666_3333_4444;
    localparam logic [63:0] C  = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] D  = 64'h9999_9999_3333_4444;
    localparam logic [63:0] M1 = 64'hFFFF_FFFF_0000_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] op = '0;
    logic sel = 1'b1, wvalid = 1'b0, up_match_n = 1'b1, up_full_n = 1'b0;
    logic [3:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [1:0] mask_sel = '0;
    logic [3:0] act_idx;
    logic [63:0] rdata;
    logic rvalid, match_n, multi_n, full_n;
    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cam_cascade_top dut (
        .clk(clk), .rst_n(rst_n), .op(op), .sel(sel), .addr(addr), .wdata(wdata),
        .wvalid(wvalid), .mask_sel(mask_sel), .up_match_n(up_match_n), .up_full_n(up_full_n),
        .act_idx(act_idx), .rdata(rdata), .rvalid(rvalid),
        .match_n(match_n), .multi_n(multi_n), .full_n(full_n)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  addr;
        logic [63:0] data;
        logic [1:0]  ms;
        logic        wv;
        logic        sel;
        logic [3:0]  act;
        logic        mn;
        logic        mm;
        logic [63:0] rd;
        logic        rv;
    } vec_t;

    // op, addr, data, mask_sel, wvalid, sel | act_idx, match_n, multi_n, rdata, rvalid
    localparam vec_t VECS [19] = '{
        '{3'd1, 4'd3, A,   2'd0, 1'b1, 1'b1, 4'd3,  1'b1, 1'b1, 64'd0, 1'b0},
        '{3'd1, 4'd7, A,   2'd0, 1'b1, 1'b1, 4'd7,  1'b1, 1'b1, 64'd0, 1'b0},
        '{3'd1, 4'd5, B,   2'd0, 1'b1, 1'b1, 4'd5,  1'b1, 1'b1, 64'd0, 1'b0},
        '{3'd1, 4'd1, A,   2'd0, 1'b0, 1'b1, 4'd1,  1'b1, 1'b1, 64'd0, 1'b0},
        '{3'd4, 4'd0, A,   2'd0, 1'b0, 1'b1, 4'd3,  1'b0, 1'b0, 64'd0, 1'b0}, // R2: empty entry 1 skipped
        '{3'd5, 4'd0, A,   2'd0, 1'b0, 1'b1, 4'd7,  1'b0, 1'b0, 64'd0, 1'b0},
        '{3'd5, 4'd0, A,   2'd0, 1'b0, 1'b1, 4'd15, 1'b0, 1'b0, 64'd0, 1'b0},
        '{3'd4, 4'd0, B,   2'd0, 1'b0, 1'b1, 4'd5,  1'b0, 1'b1, 64'd0, 1'b0},
        '{3'd4, 4'd0, C,   2'd0, 1'b0, 1'b1, 4'd15, 1'b1, 1'b1, 64'd0, 1'b0},
        '{3'd7, 4'd0, M1,  2'd1, 1'b0, 1'b1, 4'd15, 1'b1, 1'b1, 64'd0, 1'b0},
        '{3'd4, 4'd0, D,   2'd1, 1'b0, 1'b1, 4'd3,  1'b0, 1'b0, 64'd0, 1'b0}, // R2: upper half ignored
        '{3'd6, 4'd3, 64'd0, 2'd0, 1'b0, 1'b1, 4'd3, 1'b0, 1'b0, 64'd0, 1'b0},
        '{3'd4, 4'd0, A,   2'd0, 1'b0, 1'b1, 4'd7,  1'b0, 1'b1, 64'd0, 1'b0},
        '{3'd3, 4'd0, C,   2'd0, 1'b0, 1'b1, 4'd0,  1'b0, 1'b1, 64'd0, 1'b0},
        '{3'd3, 4'd0, C,   2'd0, 1'b0, 1'b1, 4'd1,  1'b0, 1'b1, 64'd0, 1'b0},
        '{3'd2, 4'd1, 64'd0, 2'd0, 1'b0, 1'b1, 4'd1, 1'b0, 1'b1, C,    1'b1},
        '{3'd4, 4'd0, A,   2'd0, 1'b0, 1'b0, 4'd15, 1'b1, 1'b1, 64'd0, 1'b0},
        '{3'd2, 4'd3, 64'd0, 2'd0, 1'b0, 1'b1, 4'd3, 1'b1, 1'b1, A,    1'b0},
        '{3'd2, 4'd7, 64'd0, 2'd0, 1'b0, 1'b1, 4'd7, 1'b1, 1'b1, A,    1'b1}
    };

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic string idx_tag(input logic [2:0] o, input logic s);
        case (o)
            3'd1, 3'd2: return "R1";
            3'd3, 3'd6: return "R7";
            3'd4:       return s ? "R3" : "R9";
            3'd5:       return "R8";
            default:    return "R10";
        endcase
    endfunction

    task automatic issue(input logic [2:0] o, input logic [3:0] a, input logic [63:0] d,
                         input logic [1:0] ms, input logic wv, input logic s);
        @(negedge clk);
        op = o; addr = a; wdata = d; mask_sel = ms; wvalid = wv; sel = s;
        @(negedge clk);
        op = 3'd0; sel = 1'b1;
    endtask

    initial begin
        logic [15:0] occ_model;
        logic [3:0]  expect_idx;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 act_idx", 64'(act_idx), 64'hF);
        chk("R11 rdata", rdata, 64'd0);
        chk("R11 rvalid", 64'(rvalid), 64'd0);
        chk("R11 match_n", 64'(match_n), 64'd1);
        chk("R11 multi_n", 64'(multi_n), 64'd1);
        chk("R11 full_n", 64'(full_n), 64'd1);
        rst_n = 1'b1;

        foreach (VECS[i]) begin
            issue(VECS[i].op, VECS[i].addr, VECS[i].data, VECS[i].ms, VECS[i].wv, VECS[i].sel);
            chk(idx_tag(VECS[i].op, VECS[i].sel), 64'(act_idx), 64'(VECS[i].act));
            chk("R4 match_n", 64'(match_n), 64'(VECS[i].mn));
            chk("R5 multi_n", 64'(multi_n), 64'(VECS[i].mm));
            if (VECS[i].op == 3'd2) begin
                chk("R1 rdata", rdata, VECS[i].rd);
                chk("R1 rvalid", 64'(rvalid), 64'(VECS[i].rv));
            end
        end

        // R7: fill the remaining empty slots, predicting each landing index
        occ_model = 16'b0000_0000_1010_0011;
        for (int k = 0; k < 12; k++) begin
            expect_idx = 4'hF;
            for (int j = 15; j >= 0; j--) if (!occ_model[j]) expect_idx = 4'(j);
            issue(3'd3, 4'd0, 64'hF000_0000 + 64'(k), 2'd0, 1'b0, 1'b1);
            chk("R7 slot index", 64'(act_idx), 64'(expect_idx));
            occ_model[expect_idx] = 1'b1;
            if (k == 0) chk("R6 not full", 64'(full_n), 64'd1);
        end
        chk("R6 full with up low", 64'(full_n), 64'd0);
        @(negedge clk); up_full_n = 1'b1; #1;
        chk("R6 up full high", 64'(full_n), 64'd1);
        @(negedge clk); up_full_n = 1'b0; #1;
        issue(3'd3, 4'd0, C, 2'd0, 1'b0, 1'b1);
        chk("R7 write when full", 64'(act_idx), 64'hF);
        issue(3'd2, 4'd15, 64'd0, 2'd0, 1'b0, 1'b1);
        chk("R7 full write ignored", rdata, 64'hF000_000B);
        issue(3'd6, 4'd9, 64'd0, 2'd0, 1'b0, 1'b1);
        chk("R7 remove index", 64'(act_idx), 64'd9);
        chk("R6 remove frees", 64'(full_n), 64'd1);

        // R4/R5: chained flag behaviour
        @(negedge clk); up_match_n = 1'b0; #1;
        chk("R4 upstream match", 64'(match_n), 64'd0);
        chk("R5 no local hit", 64'(multi_n), 64'd1);
        issue(3'd4, 4'd0, A, 2'd0, 1'b0, 1'b1);
        chk("R3 single hit", 64'(act_idx), 64'd7);
        chk("R5 one hit upstream low", 64'(multi_n), 64'd0);
        @(negedge clk); up_match_n = 1'b1; #1;
        chk("R5 one hit upstream high", 64'(multi_n), 64'd1);
        chk("R4 local match", 64'(match_n), 64'd0);
        issue(3'd4, 4'd0, C, 2'd0, 1'b0, 1'b1);
        chk("R5 two hits", 64'(multi_n), 64'd0);
        chk("R3 lowest of two", 64'(act_idx), 64'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule